// File: doc/BRIEF.md
# Fault latching and reporting unit

This block sits beside a motor bridge controller. It collects the raw detector lines: supply undervoltage, charge-pump undervoltage, eight per-transistor overcurrent lines, open-load on each winding, stall, thermal shutdown, the two temperature warnings and a serial-protocol error. It keeps one sticky diagnostic bit per source and folds those bits into summary flags. From them it drives an active-low fault pin.

Each source class follows its own rule. Overcurrent either stays latched or retries by itself after a parameterised number of quiet cycles. Thermal shutdown either latches or follows its detector. The protocol error drops only once the error has gone and a clear has been issued. The temperature warnings and the stall report reach the pin only when their report enables are set. A clear-faults pulse and a sleep-reset pulse both act as a clear. When a clear and a fresh event arrive in the same cycle, the event wins.

Top module: `fault_report_unit`

## Requirements
- R1: While rst_ni is low, all three status bytes read 0x00 and fault_no_o is 1.
- R2: Status byte 0, from bit 7 down to bit 0, holds: fault summary, protocol error, undervoltage, charge-pump undervoltage, overcurrent summary, stall, temperature summary, open-load summary. Bit 7 is always the inverse of fault_no_o.
- R3: A raw source that is high at a clock edge sets its status bit after that edge. The bit stays set after the raw line drops, unless a rule below says otherwise.
- R4: A clear (clr_i or sleep_rst_i high at an edge) resets every latched bit whose raw line is low at that edge. A raw line that is high in the same cycle keeps its bit set.
- R5: Status byte 1 holds the overcurrent bits with bit k taken from ocp_fet_i[k]. Byte 0 bit 3 is the OR of byte 1. Byte 0 bit 0 is the OR of the two open-load bits.
- R6: With ocp_retry_i = 0, a set overcurrent bit stays set until a clear.
- R7: With ocp_retry_i = 1, a set overcurrent bit clears by itself at the RETRY_CYCLES-th consecutive edge at which its raw line is low.
- R8: With ots_auto_i = 0, the thermal-shutdown bit latches. With ots_auto_i = 1, it takes the value its raw line had at the previous edge.
- R9: The protocol-error bit stays set until a clear arrives at an edge where spi_err_i is low.
- R10: Status byte 2, from bit 7 down, holds: under-temp warning, over-temp warning, thermal shutdown, learn-ok, stall, a reserved bit that always reads 0, open-load B, open-load A. Learn-ok is stl_lrn_ok_i delayed by one edge and never affects the pin. Byte 0 bit 1 is the OR of byte 2 bits 7..5.
- R11: Temperature warnings pull fault_no_o low only while tw_rep_i = 1.
- R12: Stall pulls fault_no_o low only while stl_rep_i = 1. Undervoltage, charge-pump undervoltage, overcurrent, open-load, thermal shutdown and protocol error always pull it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| uv_i | input | 1 | Raw supply undervoltage |
| cpuv_i | input | 1 | Raw charge-pump undervoltage |
| ocp_fet_i | input | 8 | Raw overcurrent, one line per transistor, in byte 1 order |
| ol_a_i | input | 1 | Raw open-load, winding A |
| ol_b_i | input | 1 | Raw open-load, winding B |
| stall_i | input | 1 | Raw stall detect |
| ots_i | input | 1 | Raw thermal shutdown |
| otw_i | input | 1 | Raw over-temperature warning |
| utw_i | input | 1 | Raw under-temperature warning |
| spi_err_i | input | 1 | Raw serial-protocol error |
| stl_lrn_ok_i | input | 1 | Stall-learn success flag |
| ocp_retry_i | input | 1 | 1 selects overcurrent auto-retry |
| ots_auto_i | input | 1 | 1 selects thermal-shutdown auto-recovery |
| tw_rep_i | input | 1 | Report temperature warnings on the pin |
| stl_rep_i | input | 1 | Report stall on the pin |
| clr_i | input | 1 | Clear-faults pulse |
| sleep_rst_i | input | 1 | Sleep-reset pulse, acts as a clear |
| status0_o | output | 8 | Summary status byte |
| status1_o | output | 8 | Per-transistor overcurrent byte |
| status2_o | output | 8 | Detail status byte |
| fault_no_o | output | 1 | Active-low fault pin |

## Verification
The bench builds the unit with RETRY_CYCLES = 4. At that value the auto-retry window is short enough to observe both the last edge at which the bit is still held and the edge at which it drops. A table drives every source alone, plus one mixed pattern, under both settings of each report enable. Each row is followed by a clear. Directed cases then cover a clear that coincides with an event, the two thermal modes, the protocol-error release rule and the sleep-reset path.

// File: rtl/fault_rpt_pkg.sv
package fault_rpt_pkg;
  localparam int unsigned N_FET = 8;
  localparam int unsigned N_GEN = 8;

  typedef enum int unsigned {
    KIND_LATCH  = 0,
    KIND_RETRY  = 1,
    KIND_FOLLOW = 2
  } cell_kind_e;

  // slots of the general sticky sources
  localparam int unsigned G_SPI   = 0;
  localparam int unsigned G_UV    = 1;
  localparam int unsigned G_CPUV  = 2;
  localparam int unsigned G_OLA   = 3;
  localparam int unsigned G_OLB   = 4;
  localparam int unsigned G_STALL = 5;
  localparam int unsigned G_OTW   = 6;
  localparam int unsigned G_UTW   = 7;
endpackage

// File: rtl/fault_latch_cell.sv
module fault_latch_cell
  import fault_rpt_pkg::*;
#(
  parameter cell_kind_e  KIND         = KIND_LATCH,
  parameter int unsigned RETRY_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic clr_i,
  input  logic mode_i,
  output logic flag_o
);
  localparam bit FOLLOW = (KIND == KIND_FOLLOW);

  logic q, q_next, expire;

  generate
    if (KIND == KIND_RETRY) begin : g_retry
      localparam int unsigned CW = (RETRY_CYCLES > 1) ? $clog2(RETRY_CYCLES) : 1;
      localparam logic [CW-1:0] LAST = CW'(RETRY_CYCLES - 1);
      logic [CW-1:0] cnt;
      logic counting;
      assign counting = q & ~raw_i & ~clr_i & mode_i;
      assign expire   = counting & (cnt == LAST);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 cnt <= '0;
        else if (!counting || expire) cnt <= '0;
        else                         cnt <= cnt + CW'(1);
      end
    end else begin : g_plain
      assign expire = 1'b0;
    end
  endgenerate

  // a new event always wins over clear or expiry
  always_comb begin
    if (FOLLOW && mode_i) q_next = raw_i;
    else                  q_next = raw_i | (q & ~clr_i & ~expire);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= 1'b0;
    else         q <= q_next;
  end

  assign flag_o = q;
endmodule

// File: rtl/fault_summary.sv
module fault_summary
  import fault_rpt_pkg::*;
(
  input  logic [N_GEN-1:0] gen_q_i,
  input  logic [N_FET-1:0] fet_q_i,
  input  logic             ots_q_i,
  input  logic             lrn_q_i,
  input  logic             tw_rep_i,
  input  logic             stl_rep_i,
  output logic [7:0]       status0_o,
  output logic [7:0]       status1_o,
  output logic [7:0]       status2_o,
  output logic             fault_no_o
);
  logic ocp_any, ol_any, temp_any, warn_any, fault;

  assign ocp_any  = |fet_q_i;
  assign ol_any   = gen_q_i[G_OLA] | gen_q_i[G_OLB];
  assign warn_any = gen_q_i[G_OTW] | gen_q_i[G_UTW];
  assign temp_any = warn_any | ots_q_i;

  assign fault = gen_q_i[G_SPI] | gen_q_i[G_UV] | gen_q_i[G_CPUV] | ocp_any |
                 ol_any | ots_q_i | (stl_rep_i & gen_q_i[G_STALL]) |
                 (tw_rep_i & warn_any);

  assign status0_o = {fault, gen_q_i[G_SPI], gen_q_i[G_UV], gen_q_i[G_CPUV],
                      ocp_any, gen_q_i[G_STALL], temp_any, ol_any};
  assign status1_o = fet_q_i;
  assign status2_o = {gen_q_i[G_UTW], gen_q_i[G_OTW], ots_q_i, lrn_q_i,
                      gen_q_i[G_STALL], 1'b0, gen_q_i[G_OLB], gen_q_i[G_OLA]};
  assign fault_no_o = ~fault;
endmodule

// File: rtl/fault_report_unit.sv
module fault_report_unit
  import fault_rpt_pkg::*;
#(
  parameter int unsigned RETRY_CYCLES = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       uv_i,
  input  logic       cpuv_i,
  input  logic [7:0] ocp_fet_i,
  input  logic       ol_a_i,
  input  logic       ol_b_i,
  input  logic       stall_i,
  input  logic       ots_i,
  input  logic       otw_i,
  input  logic       utw_i,
  input  logic       spi_err_i,
  input  logic       stl_lrn_ok_i,
  input  logic       ocp_retry_i,
  input  logic       ots_auto_i,
  input  logic       tw_rep_i,
  input  logic       stl_rep_i,
  input  logic       clr_i,
  input  logic       sleep_rst_i,
  output logic [7:0] status0_o,
  output logic [7:0] status1_o,
  output logic [7:0] status2_o,
  output logic       fault_no_o
);
  logic             clr;
  logic [N_GEN-1:0] gen_raw, gen_q;
  logic [N_FET-1:0] fet_q;
  logic             ots_q, lrn_q;

  assign clr = clr_i | sleep_rst_i;

  always_comb begin
    gen_raw          = '0;
    gen_raw[G_SPI]   = spi_err_i;
    gen_raw[G_UV]    = uv_i;
    gen_raw[G_CPUV]  = cpuv_i;
    gen_raw[G_OLA]   = ol_a_i;
    gen_raw[G_OLB]   = ol_b_i;
    gen_raw[G_STALL] = stall_i;
    gen_raw[G_OTW]   = otw_i;
    gen_raw[G_UTW]   = utw_i;
  end

  for (genvar i = 0; i < N_GEN; i++) begin : g_gen
    fault_latch_cell #(.KIND(KIND_LATCH), .RETRY_CYCLES(RETRY_CYCLES)) u_cell (
      .clk_i (clk_i), .rst_ni(rst_ni), .raw_i(gen_raw[i]), .clr_i(clr),
      .mode_i(1'b0), .flag_o(gen_q[i])
    );
  end

  for (genvar k = 0; k < N_FET; k++) begin : g_fet
    fault_latch_cell #(.KIND(KIND_RETRY), .RETRY_CYCLES(RETRY_CYCLES)) u_cell (
      .clk_i (clk_i), .rst_ni(rst_ni), .raw_i(ocp_fet_i[k]), .clr_i(clr),
      .mode_i(ocp_retry_i), .flag_o(fet_q[k])
    );
  end

  fault_latch_cell #(.KIND(KIND_FOLLOW), .RETRY_CYCLES(RETRY_CYCLES)) u_ots (
    .clk_i (clk_i), .rst_ni(rst_ni), .raw_i(ots_i), .clr_i(clr),
    .mode_i(ots_auto_i), .flag_o(ots_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lrn_q <= 1'b0;
    else         lrn_q <= stl_lrn_ok_i;
  end

  fault_summary u_sum (
    .gen_q_i   (gen_q),
    .fet_q_i   (fet_q),
    .ots_q_i   (ots_q),
    .lrn_q_i   (lrn_q),
    .tw_rep_i  (tw_rep_i),
    .stl_rep_i (stl_rep_i),
    .status0_o (status0_o),
    .status1_o (status1_o),
    .status2_o (status2_o),
    .fault_no_o(fault_no_o)
  );
endmodule

// File: rtl/fault_report_chk.sv
module fault_report_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       uv_i,
  input logic       ots_i,
  input logic       spi_err_i,
  input logic       ocp_retry_i,
  input logic       ots_auto_i,
  input logic       clr_i,
  input logic       sleep_rst_i,
  input logic [7:0] status0_o,
  input logic [7:0] status1_o,
  input logic [7:0] status2_o,
  input logic       fault_no_o
);
  a_r2_pin_inverse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status0_o[7] != fault_no_o);

  a_r3_uv_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |=> status0_o[5]);

  a_r4_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i || sleep_rst_i) && !uv_i) |=> !status0_o[5]);

  a_r5_ocp_summary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status0_o[3] == (|status1_o));

  a_r6_ocp_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ocp_retry_i && !clr_i && !sleep_rst_i && status1_o[0]) |=> status1_o[0]);

  a_r8_ots_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ots_auto_i |=> (status2_o[5] == $past(ots_i)));

  a_r9_spi_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status0_o[6] && !clr_i && !sleep_rst_i) |=> status0_o[6]);

  a_r9_spi_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_err_i |=> status0_o[6]);

  a_r10_temp_summary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status0_o[1] == (|status2_o[7:5]));
endmodule

bind fault_report_unit fault_report_chk u_chk (.*);

// File: tb/fault_report_unit_bench.sv
`timescale 1ns/1ps
module fault_report_unit_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic uv_i = 0, cpuv_i = 0, ol_a_i = 0, ol_b_i = 0, stall_i = 0;
  logic ots_i = 0, otw_i = 0, utw_i = 0, spi_err_i = 0, stl_lrn_ok_i = 0;
  logic [7:0] ocp_fet_i = '0;
  logic ocp_retry_i = 0, ots_auto_i = 0, tw_rep_i = 0, stl_rep_i = 1;
  logic clr_i = 0, sleep_rst_i = 0;
  logic [7:0] status0_o, status1_o, status2_o;
  logic fault_no_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fault_report_unit #(.RETRY_CYCLES(4)) u_fault_report_unit (
    .clk_i(clk), .rst_ni(rst_ni), .uv_i(uv_i), .cpuv_i(cpuv_i),
    .ocp_fet_i(ocp_fet_i), .ol_a_i(ol_a_i), .ol_b_i(ol_b_i),
    .stall_i(stall_i), .ots_i(ots_i), .otw_i(otw_i), .utw_i(utw_i),
    .spi_err_i(spi_err_i), .stl_lrn_ok_i(stl_lrn_ok_i),
    .ocp_retry_i(ocp_retry_i), .ots_auto_i(ots_auto_i),
    .tw_rep_i(tw_rep_i), .stl_rep_i(stl_rep_i), .clr_i(clr_i),
    .sleep_rst_i(sleep_rst_i), .status0_o(status0_o),
    .status1_o(status1_o), .status2_o(status2_o), .fault_no_o(fault_no_o)
  );

  // src bits 8..0: spi, uv, cpuv, ol_a, ol_b, stall, ots, otw, utw
  typedef struct packed {
    logic [7:0] fet;
    logic [8:0] src;
    logic       twr;
    logic       str;
    logic [7:0] e0;
    logic [7:0] e1;
    logic [7:0] e2;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{8'h01, 9'b000000000, 1'b0, 1'b1, 8'h88, 8'h01, 8'h00},
    '{8'h80, 9'b000000000, 1'b0, 1'b1, 8'h88, 8'h80, 8'h00},
    '{8'h00, 9'b010000000, 1'b0, 1'b1, 8'hA0, 8'h00, 8'h00},
    '{8'h00, 9'b001000000, 1'b0, 1'b1, 8'h90, 8'h00, 8'h00},
    '{8'h00, 9'b000100000, 1'b0, 1'b1, 8'h81, 8'h00, 8'h01},
    '{8'h00, 9'b000010000, 1'b0, 1'b1, 8'h81, 8'h00, 8'h02},
    '{8'h00, 9'b000001000, 1'b0, 1'b1, 8'h84, 8'h00, 8'h08},
    '{8'h00, 9'b000001000, 1'b0, 1'b0, 8'h04, 8'h00, 8'h08},
    '{8'h00, 9'b000000010, 1'b0, 1'b1, 8'h02, 8'h00, 8'h40},
    '{8'h00, 9'b000000010, 1'b1, 1'b1, 8'h82, 8'h00, 8'h40},
    '{8'h00, 9'b000000001, 1'b0, 1'b1, 8'h02, 8'h00, 8'h80},
    '{8'h00, 9'b000000100, 1'b0, 1'b1, 8'h82, 8'h00, 8'h20},
    '{8'h00, 9'b100000000, 1'b0, 1'b1, 8'hC0, 8'h00, 8'h00},
    '{8'h5A, 9'b000000001, 1'b1, 1'b1, 8'h8A, 8'h5A, 8'h80}
  };

  task automatic expect_all(input string tag, input logic [7:0] e0,
                            input logic [7:0] e1, input logic [7:0] e2);
    checks++;
    if (status0_o !== e0 || status1_o !== e1 || status2_o !== e2 ||
        fault_no_o !== ~e0[7]) begin
      errors++;
      $display("FAIL %s: got %h %h %h pin=%b expected %h %h %h pin=%b",
               tag, status0_o, status1_o, status2_o, fault_no_o,
               e0, e1, e2, ~e0[7]);
    end
  endtask

  task automatic pulse_clear();
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_all("R1 reset", 8'h00, 8'h00, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk);
    expect_all("R1 after release", 8'h00, 8'h00, 8'h00);

    foreach (VECS[i]) begin
      ocp_fet_i = VECS[i].fet;
      {spi_err_i, uv_i, cpuv_i, ol_a_i, ol_b_i, stall_i, ots_i, otw_i, utw_i} = VECS[i].src;
      tw_rep_i  = VECS[i].twr;
      stl_rep_i = VECS[i].str;
      @(negedge clk);
      expect_all("R2 R3 R5 R10 R11 R12 table", VECS[i].e0, VECS[i].e1, VECS[i].e2);
      ocp_fet_i = '0;
      {spi_err_i, uv_i, cpuv_i, ol_a_i, ol_b_i, stall_i, ots_i, otw_i, utw_i} = '0;
      pulse_clear();
      expect_all("R4 clear after table row", 8'h00, 8'h00, 8'h00);
    end
    tw_rep_i = 1'b0;
    stl_rep_i = 1'b1;

    // R3 sticky after raw drops
    uv_i = 1'b1;
    @(negedge clk);
    uv_i = 1'b0;
    repeat (3) @(negedge clk);
    expect_all("R3 held after drop", 8'hA0, 8'h00, 8'h00);
    // R4 event and clear together: event wins
    uv_i = 1'b1; clr_i = 1'b1;
    @(negedge clk);
    uv_i = 1'b0; clr_i = 1'b0;
    expect_all("R4 event beats clear", 8'hA0, 8'h00, 8'h00);
    // R4 sleep reset clears
    sleep_rst_i = 1'b1;
    @(negedge clk);
    sleep_rst_i = 1'b0;
    expect_all("R4 sleep reset clears", 8'h00, 8'h00, 8'h00);

    // R6 latched overcurrent
    ocp_retry_i = 1'b0;
    ocp_fet_i = 8'h10;
    @(negedge clk);
    ocp_fet_i = '0;
    repeat (8) @(negedge clk);
    expect_all("R6 latched ocp holds", 8'h88, 8'h10, 8'h00);
    pulse_clear();

    // R7 auto retry, RETRY_CYCLES = 4
    ocp_retry_i = 1'b1;
    ocp_fet_i = 8'h04;
    repeat (5) @(negedge clk);
    expect_all("R7 held while raw high", 8'h88, 8'h04, 8'h00);
    ocp_fet_i = '0;
    repeat (3) @(negedge clk);
    expect_all("R7 still set after 3 quiet edges", 8'h88, 8'h04, 8'h00);
    @(negedge clk);
    expect_all("R7 cleared at 4th quiet edge", 8'h00, 8'h00, 8'h00);
    ocp_retry_i = 1'b0;

    // R8 thermal shutdown modes
    ots_i = 1'b1;
    @(negedge clk);
    ots_i = 1'b0;
    @(negedge clk);
    expect_all("R8 latched shutdown holds", 8'h82, 8'h00, 8'h20);
    pulse_clear();
    ots_auto_i = 1'b1;
    ots_i = 1'b1;
    @(negedge clk);
    expect_all("R8 auto shutdown set", 8'h82, 8'h00, 8'h20);
    ots_i = 1'b0;
    @(negedge clk);
    expect_all("R8 auto shutdown recovers", 8'h00, 8'h00, 8'h00);
    ots_auto_i = 1'b0;

    // R9 protocol error release rule
    spi_err_i = 1'b1; clr_i = 1'b1;
    @(negedge clk);
    expect_all("R9 clear ignored while error present", 8'hC0, 8'h00, 8'h00);
    spi_err_i = 1'b0; clr_i = 1'b0;
    repeat (3) @(negedge clk);
    expect_all("R9 holds without clear", 8'hC0, 8'h00, 8'h00);
    pulse_clear();
    expect_all("R9 released by clear", 8'h00, 8'h00, 8'h00);

    // R10 learn-ok passes through, no pin effect
    stl_lrn_ok_i = 1'b1;
    @(negedge clk);
    expect_all("R10 learn ok bit", 8'h00, 8'h00, 8'h10);
    stl_lrn_ok_i = 1'b0;
    @(negedge clk);
    expect_all("R10 learn ok follows", 8'h00, 8'h00, 8'h00);

    // R11 enabling report on a held warning pulls the pin
    otw_i = 1'b1;
    @(negedge clk);
    otw_i = 1'b0;
    expect_all("R11 warning masked", 8'h02, 8'h00, 8'h40);
    tw_rep_i = 1'b1;
    #1;
    expect_all("R11 warning reported", 8'h82, 8'h00, 8'h40);
    tw_rep_i = 1'b0;
    pulse_clear();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule